// File: doc/BRIEF.md
# Master Write Command Selector

This block decides, for every burst of a master write, whether the bus should carry a Memory Write and Invalidate (MWI) command or a plain Memory Write (MW). A write request supplies a dword start address and a dword length. The block also sees the configured cache line size and the MWI enable bit. It asks for the bus, picks the command when the grant arrives, and counts data phases. It ends the burst when the data runs out, when the target ends the transaction early, or when an MWI burst reaches a line boundary with less than a full line left.

After a burst ends with data still outstanding, the block goes back to arbitration. It then picks the command again from the new address and the new remaining count. An MWI burst that ends at a boundary is therefore followed by an MW burst for the tail. A burst cut short by the target may restart with either command. Bus handshakes are reduced to single-cycle events: `gnt` grants the bus, `dphase` accepts one dword, and `term` is a target disconnect or a latency-timer expiry.

Top module: `wr_cmd_sel`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `remaining`=0 and `cmd`=0. A request with `req_len`=0 is ignored, and `req_ready` stays 1.
- R2: The command shown during arbitration and held through the burst is encoded on `cmd` as 1 for MWI and 0 for MW. MWI is chosen only when `mwi_en`=1, the line size is supported, `cur_addr` is a multiple of the line size, and `remaining` is at least the line size. Otherwise MW is chosen.
- R3: Only the line sizes 4, 8, 16 and 32 dwords are supported. Any other `cls_cfg` value forces MW for every burst.
- R4: With `mwi_en`=0 every burst uses MW.
- R5: Each `dphase` during a burst increments `cur_addr` by one and decrements `remaining` by one. Outside a burst both values hold.
- R6: An MWI burst runs through a line boundary without stopping when at least one full line remains after it.
- R7: An MWI burst pulses `burst_stop` on the data phase that reaches a line boundary if less than a full line then remains. The block then re-arbitrates, and the tail goes out as MW.
- R8: `term` ends the burst in that cycle with `burst_stop`. A `dphase` in the same cycle still counts. If data remains, the block re-arbitrates and chooses the command afresh.
- R9: An MW burst continues until `remaining` reaches zero, unless `term` ends it first. At zero it stops and returns to idle.
- R10: `burst_start` is high exactly in a cycle that is in arbitration with `gnt`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | New write request |
| req_addr | input | AW | Start address in dwords |
| req_len | input | LW | Length in dwords |
| req_ready | output | 1 | Idle and able to take a request |
| cls_cfg | input | CW | Cache line size in dwords |
| mwi_en | input | 1 | MWI command allowed |
| gnt | input | 1 | Bus granted |
| dphase | input | 1 | One data phase accepted |
| term | input | 1 | Target disconnect or latency-timer expiry |
| cmd | output | 1 | 1 = MWI, 0 = MW |
| burst_start | output | 1 | Burst begins this cycle |
| burst_stop | output | 1 | Burst ends this cycle |
| cur_addr | output | AW | Address of the next data phase |
| remaining | output | LW | Dwords still to transfer |

## Verification
The assertions assume that `cls_cfg` and `mwi_en` do not change while a request is in progress. They also assume that addresses stay small enough that `cur_addr` does not wrap during a transfer. The stimulus changes the configuration only while `req_ready` is high, and it uses start addresses far below the address width. `gnt`, `dphase` and `term` are otherwise free in any cycle, and the reference model follows whatever pattern is driven.

// File: rtl/wr_cmd_pkg.sv
// Shared types for the master write command selector.
package wr_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARB   = 2'd1,
        ST_BURST = 2'd2
    } wr_state_e;

    typedef enum logic {
        CMD_MW  = 1'b0,
        CMD_MWI = 1'b1
    } wr_cmd_e;
endpackage

// File: rtl/wr_cls_decode.sv
// Decodes the line size setting into a "supported" flag and a low-bit mask.
// Assumes supported sizes are the powers of two from 2**MIN_LOG2 to 2**MAX_LOG2.
module wr_cls_decode #(
    parameter int CW       = 8,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 5
) (
    input  logic [CW-1:0] cls_cfg,
    output logic          cls_ok,
    output logic [CW-1:0] cls_mask
);
    localparam int NSZ = MAX_LOG2 - MIN_LOG2 + 1;

    logic [NSZ-1:0] hit;

    // One comparator per supported power-of-two size.
    for (genvar g = 0; g < NSZ; g++) begin : g_size
        assign hit[g] = (cls_cfg == CW'(1 << (MIN_LOG2 + g)));
    end

    // Flag and mask; the mask is zero for unsupported settings.
    always_comb begin
        cls_ok   = |hit;
        cls_mask = cls_ok ? (cls_cfg - CW'(1)) : '0;
    end
endmodule

// File: rtl/wr_cmd_eval.sv
// Command choice and boundary detection for the write selector.
// Assumes AW >= CW and LW > CW.
module wr_cmd_eval #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] rem,
    input  logic [AW-1:0] nxt_addr,
    input  logic [LW-1:0] nxt_rem,
    input  logic [CW-1:0] cls_cfg,
    input  logic          cls_ok,
    input  logic [CW-1:0] cls_mask,
    input  logic          mwi_en,
    output logic          use_mwi,
    output logic          tail_short
);
    logic aligned;
    logic nxt_bnd;

    // MWI needs enable, a supported size, alignment and a full line of data.
    always_comb begin
        aligned = ((addr[CW-1:0] & cls_mask) == '0);
        use_mwi = mwi_en && cls_ok && aligned && (rem >= LW'(cls_cfg));
    end

    // The next address sits on a boundary with less than a line behind it.
    always_comb begin
        nxt_bnd    = ((nxt_addr[CW-1:0] & cls_mask) == '0);
        tail_short = nxt_bnd && (nxt_rem < LW'(cls_cfg));
    end
endmodule

// File: rtl/wr_xfer_track.sv
// Holds the current address and remaining dword count of a write transfer.
// Assumes load and step are never high together.
module wr_xfer_track #(
    parameter int AW = 32,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [LW-1:0] ld_len,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [LW-1:0] rem,
    output logic [AW-1:0] nxt_addr,
    output logic [LW-1:0] nxt_rem
);
    // Values after the data phase of this cycle, if there is one.
    always_comb begin
        nxt_addr = addr + AW'(step);
        nxt_rem  = rem - LW'(step);
    end

    // Load on a new request, advance on each data phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            rem  <= '0;
        end else if (load) begin
            addr <= ld_addr;
            rem  <= ld_len;
        end else begin
            addr <= nxt_addr;
            rem  <= nxt_rem;
        end
    end
endmodule

// File: rtl/wr_cmd_sel.sv
// Master write command selector: per-burst MWI/MW choice, with the command
// chosen again after every early termination or line-boundary stop.
// Assumes cls_cfg and mwi_en are stable while a request is in progress.
module wr_cmd_sel
    import wr_cmd_pkg::*;
#(
    parameter int AW       = 32,
    parameter int LW       = 16,
    parameter int CW       = 8,
    parameter int MIN_LOG2 = 2,
    parameter int MAX_LOG2 = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          req_ready,
    input  logic [CW-1:0] cls_cfg,
    input  logic          mwi_en,
    input  logic          gnt,
    input  logic          dphase,
    input  logic          term,
    output logic          cmd,
    output logic          burst_start,
    output logic          burst_stop,
    output logic [AW-1:0] cur_addr,
    output logic [LW-1:0] remaining
);
    wr_state_e     state_q, state_d;
    wr_cmd_e       cmd_q;
    logic          cls_ok;
    logic [CW-1:0] cls_mask;
    logic          use_mwi, tail_short;
    logic          load, step;
    logic [AW-1:0] nxt_addr;
    logic [LW-1:0] nxt_rem;

    wr_cls_decode #(.CW(CW), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_cls (
        .cls_cfg (cls_cfg),
        .cls_ok  (cls_ok),
        .cls_mask(cls_mask)
    );

    wr_xfer_track #(.AW(AW), .LW(LW)) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .ld_addr (req_addr),
        .ld_len  (req_len),
        .step    (step),
        .addr    (cur_addr),
        .rem     (remaining),
        .nxt_addr(nxt_addr),
        .nxt_rem (nxt_rem)
    );

    wr_cmd_eval #(.AW(AW), .LW(LW), .CW(CW)) u_eval (
        .addr      (cur_addr),
        .rem       (remaining),
        .nxt_addr  (nxt_addr),
        .nxt_rem   (nxt_rem),
        .cls_cfg   (cls_cfg),
        .cls_ok    (cls_ok),
        .cls_mask  (cls_mask),
        .mwi_en    (mwi_en),
        .use_mwi   (use_mwi),
        .tail_short(tail_short)
    );

    // Request acceptance, data-phase stepping and burst strobes.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        load        = req_ready && req_valid && (req_len != '0);
        step        = (state_q == ST_BURST) && dphase;
        burst_start = (state_q == ST_ARB) && gnt;
        burst_stop  = (state_q == ST_BURST) &&
                      (term || (step && nxt_rem == '0) ||
                       (cmd_q == CMD_MWI && step && tail_short));
        unique case (state_q)
            ST_ARB:   cmd = use_mwi;
            ST_BURST: cmd = cmd_q;
            default:  cmd = CMD_MW;
        endcase
    end

    // Next-state choice: idle -> arbitrate -> burst -> arbitrate or idle.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load) state_d = ST_ARB;
            ST_ARB:   if (gnt) state_d = ST_BURST;
            ST_BURST: if (burst_stop) state_d = (nxt_rem == '0) ? ST_IDLE : ST_ARB;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register and the command latched when the bus is granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cmd_q   <= CMD_MW;
        end else begin
            state_q <= state_d;
            if (burst_start) cmd_q <= use_mwi ? CMD_MWI : CMD_MW;
        end
    end
endmodule

// File: rtl/wr_cmd_sel_chk.sv
// Port-level properties of the master write command selector.
// Assumes configuration is stable per request and addresses do not wrap.
module wr_cmd_sel_chk #(
    parameter int AW = 32,
    parameter int LW = 16,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [LW-1:0] req_len,
    input logic          req_ready,
    input logic [CW-1:0] cls_cfg,
    input logic          mwi_en,
    input logic          gnt,
    input logic          term,
    input logic          cmd,
    input logic          burst_start,
    input logic          burst_stop,
    input logic [AW-1:0] cur_addr,
    input logic [LW-1:0] remaining
);
    logic          sz_legal;
    logic [AW-1:0] lmask;

    // Independent view of the legal sizes and the matching address mask.
    always_comb begin
        sz_legal = (cls_cfg == 4) || (cls_cfg == 8) || (cls_cfg == 16) || (cls_cfg == 32);
        lmask    = AW'(cls_cfg) - AW'(1);
    end

    a_r1_zero_len_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready && req_valid && req_len == '0 |=> req_ready);

    a_r2_mwi_legal: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start && cmd |-> mwi_en && sz_legal && ((cur_addr & lmask) == '0) &&
                               (remaining >= LW'(cls_cfg)));

    a_r3_mw_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start && !sz_legal |-> !cmd);

    a_r4_mw_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start && !mwi_en |-> !cmd);

    a_r5_rem_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> remaining <= $past(remaining));

    a_r7_mwi_stop_on_bnd: assert property (@(posedge clk) disable iff (!rst_n)
        burst_stop && cmd && !term |=> (remaining == '0) || ((cur_addr & lmask) == '0));

    a_r10_start_when_granted: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |-> gnt && !req_ready);

    a_r10_start_stop_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({burst_start, burst_stop}));
endmodule

bind wr_cmd_sel wr_cmd_sel_chk #(.AW(AW), .LW(LW), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .req_ready  (req_ready),
    .cls_cfg    (cls_cfg),
    .mwi_en     (mwi_en),
    .gnt        (gnt),
    .term       (term),
    .cmd        (cmd),
    .burst_start(burst_start),
    .burst_stop (burst_stop),
    .cur_addr   (cur_addr),
    .remaining  (remaining)
);

// File: tb/wr_cmd_sel_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model compared on every falling edge,
// plus directed scenarios whose burst command sequences are known.
module wr_cmd_sel_tb_top;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready;
    logic [CW-1:0] cls_cfg = 8'd8;
    logic          mwi_en = 1'b1;
    logic          gnt = 1'b0;
    logic          dphase = 1'b0;
    logic          term = 1'b0;
    logic          cmd, burst_start, burst_stop;
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] remaining;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // model state: 0 idle, 1 arbitrating, 2 bursting
    int m_st = 0, m_addr = 0, m_rem = 0, m_cmd = 0;
    int starts_q[$];

    always #2 clk = ~clk;

    wr_cmd_sel #(.AW(AW), .LW(LW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ready(req_ready), .cls_cfg(cls_cfg), .mwi_en(mwi_en),
        .gnt(gnt), .dphase(dphase), .term(term), .cmd(cmd), .burst_start(burst_start),
        .burst_stop(burst_stop), .cur_addr(cur_addr), .remaining(remaining)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit sz_ok(input int c);
        return (c == 4) || (c == 8) || (c == 16) || (c == 32);
    endfunction

    // Reference model: compare then advance, once per cycle on the falling edge.
    always @(negedge clk) begin
        int  c, sel, e_cmd, e_start, e_stop, na, nr;
        c = int'(cls_cfg);
        if (!rst_n) begin
            m_st = 0; m_addr = 0; m_rem = 0; m_cmd = 0;
        end else begin
            sel = (mwi_en && sz_ok(c) && (m_addr % c) == 0 && m_rem >= c) ? 1 : 0;
            e_cmd = (m_st == 1) ? sel : (m_st == 2) ? m_cmd : 0;
            e_start = (m_st == 1 && gnt) ? 1 : 0;
            na = m_addr; nr = m_rem; e_stop = 0;
            if (m_st == 2) begin
                if (dphase) begin na = m_addr + 1; nr = m_rem - 1; end
                if (term || (dphase && nr == 0) ||
                    (m_cmd == 1 && dphase && (na % c) == 0 && nr < c)) e_stop = 1;
            end
            chk(req_ready == (m_st == 0), "R1 req_ready", req_ready, m_st == 0);
            chk(cmd == e_cmd, "R2 cmd", cmd, e_cmd);
            chk(burst_start == e_start, "R10 burst_start", burst_start, e_start);
            chk(burst_stop == e_stop, "R8 burst_stop", burst_stop, e_stop);
            chk(int'(remaining) == m_rem, "R5 remaining", remaining, m_rem);
            chk(int'(cur_addr) == m_addr, "R5 cur_addr", cur_addr, m_addr);
            if (burst_start) starts_q.push_back(int'(cmd));
            case (m_st)
                0: if (req_valid && req_len != 0) begin
                       m_st = 1; m_addr = int'(req_addr); m_rem = int'(req_len);
                   end
                1: if (gnt) begin m_st = 2; m_cmd = sel; end
                default: begin
                    m_addr = na; m_rem = nr;
                    if (e_stop) m_st = (nr == 0) ? 0 : 1;
                end
            endcase
        end
    end

    // Directed request with the bus always granted; term is raised in cycle t.
    task automatic run_req(input int a, input int l, input int c, input int m,
                           input int t, input string req, input int exp_q[$]);
        cls_cfg = CW'(c); mwi_en = m[0]; gnt = 1; dphase = 1; term = 0;
        starts_q.delete();
        req_addr = AW'(a); req_len = LW'(l); req_valid = 1;
        @(posedge clk); #1 req_valid = 0;
        for (int k = 0; k < 400 && !req_ready; k++) begin
            term = (k == t);
            @(posedge clk); #1;
        end
        term = 0;
        @(posedge clk); #1;
        chk(starts_q.size() == exp_q.size(), {req, " burst count"}, starts_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < starts_q.size(); i++)
            chk(starts_q[i] == exp_q[i], {req, " burst cmd"}, starts_q[i], exp_q[i]);
        chk(req_ready == 1 && remaining == 0, {req, " back to idle"}, remaining, 0);
    endtask

    // Random request with random grant, data and termination timing.
    task automatic run_rand(input int a, input int l, input int c, input int m);
        cls_cfg = CW'(c); mwi_en = m[0];
        req_addr = AW'(a); req_len = LW'(l); req_valid = 1;
        @(posedge clk); #1 req_valid = 0;
        for (int k = 0; k < 2000 && !req_ready; k++) begin
            gnt = ($urandom_range(0, 2) != 0);
            dphase = ($urandom_range(0, 3) != 0);
            term = ($urandom_range(0, 11) == 0);
            @(posedge clk); #1;
        end
        gnt = 0; dphase = 0; term = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(req_ready == 1 && remaining == 0 && cmd == 0, "R1 reset state", remaining, 0);
        @(posedge clk); #1;
        // R1: zero-length request ignored
        run_req(16, 0, 8, 1, -1, "R1 zero length", '{});
        // R6, R7: MWI across boundary 8, stop at 16 with 4 left, tail as MW
        run_req(0, 20, 8, 1, -1, "R7 boundary stop", '{1, 0});
        // R9: unaligned start, single MW burst to the end
        run_req(3, 20, 8, 1, -1, "R9 MW to end", '{0});
        // R3: unsupported size 12 forces MW
        run_req(0, 24, 12, 1, -1, "R3 unsupported size", '{0});
        // R4: enable off forces MW
        run_req(0, 24, 8, 0, -1, "R4 enable off", '{0});
        // R8: terminate after four phases, restart at address 4 as MW
        run_req(0, 24, 8, 1, 4, "R8 early termination", '{1, 0});
        // R8: terminate an MW burst at address 8 with 16 left, restart as MWI
        run_req(5, 19, 8, 1, 3, "R8 restart as MWI", '{0, 1});
        // R6: long MWI burst over several 4-dword lines
        run_req(32, 16, 4, 1, -1, "R6 multi-line MWI", '{1});
        // R2: full exact line at 32-dword size
        run_req(64, 32, 32, 1, -1, "R2 exact line", '{1});
        gnt = 0; dphase = 0;
        for (int r = 0; r < 60; r++) begin
            int sz[5] = '{4, 8, 16, 32, 12};
            run_rand(4 * $urandom_range(0, 20) + $urandom_range(0, 1) * $urandom_range(0, 3),
                     $urandom_range(0, 40), sz[$urandom_range(0, 4)], $urandom_range(0, 3) != 0);
            repeat (2) @(posedge clk);
            #1;
        end
        finished = 1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule